// File: doc/BRIEF.md
# Macro ALU with Carry Flag

This block is the arithmetic and logic unit used by a small macro sequencer. It takes two operands and a 5-bit operation code, and it computes a result in the same cycle. A single carry flag is held in a register. The four arithmetic operations read this flag and write it back. The five bitwise operations pass the flag through untouched.

For subtraction the flag means "no borrow". Subtract-with-borrow takes one extra away only when the flag is clear. This lets multi-word subtraction chain in the same way that multi-word addition does.

An operation code that names no operation gives a zero result and raises an illegal-operation output. Such a code leaves the flag as it was. A separate update-enable input gates every write to the flag, so the sequencer can compute without disturbing it.

Top module: `macro_alu`

## Requirements
- R1: Code 0 (add) gives result = (a + b) mod 2^W. When update is enabled, the flag after the clock edge is 1 exactly when a + b > 2^W - 1.
- R2: Code 1 (add with carry) gives (a + b + c) mod 2^W, where c is the current flag. When enabled, the flag becomes 1 exactly when a + b + c > 2^W - 1.
- R3: Code 2 (subtract) gives (a - b) mod 2^W. When enabled, the flag becomes 1 exactly when a >= b.
- R4: Code 3 (subtract with borrow) gives (a - b - 1) mod 2^W when the flag is 0, and (a - b) mod 2^W when the flag is 1. When enabled, the flag becomes 1 exactly when that difference is not negative.
- R5: Codes 8 to 12 give, in order: a xor b, a or b, a and b, a and not b, and not (a and b).
- R6: Codes 8 to 12 never change the flag, whatever the update-enable input is.
- R7: Codes 4 to 7 and 13 to 31 give result 0, set the illegal output to 1, and leave the flag unchanged. Every valid code drives the illegal output to 0.
- R8: While the update-enable input is 0, the flag keeps its value across the clock edge for every code.
- R9: While the active-low reset is asserted, the flag reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; it clears the flag |
| upd_en | input | 1 | Allows an arithmetic operation to write the flag |
| op_code | input | 5 | Operation select |
| opnd_a | input | DATA_W | First operand |
| opnd_b | input | DATA_W | Second operand |
| result | output | DATA_W | Combinational result |
| carry_q | output | 1 | Registered carry / no-borrow flag |
| illegal_op | output | 1 | High when op_code names no operation |

## Verification
The assertions assume that op_code, the operands and upd_en are steady around each rising edge. They also assume that the flag starts from a known value after reset. The bench changes inputs only on falling edges and holds them through the next rising edge.

Before each vector, the bench loads the flag to a chosen value using a plain add. Every operation code is then swept against every operand pair and both flag values, with a 4-bit data path. The update-enable input varies across these vectors, so the held-flag cases are covered alongside the written-flag cases.

// File: rtl/malu_pkg.sv
package malu_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBB  = 5'd3,
    OP_XOR  = 5'd8,
    OP_OR   = 5'd9,
    OP_AND  = 5'd10,
    OP_ANDN = 5'd11,
    OP_NAND = 5'd12
  } malu_op_e;

  typedef struct packed {
    logic legal;   // code names an operation
    logic arith;   // uses the adder and may write the flag
    logic invert;  // subtract family: b is inverted
    logic chain;   // adder carry-in comes from the flag
  } malu_ctl_t;

endpackage

// File: rtl/malu_decode.sv
module malu_decode
  import malu_pkg::*;
(
  input  logic [4:0] op_code,
  output malu_ctl_t  ctl
);

  always_comb begin
    ctl = '0;
    unique case (op_code)
      OP_ADD:  ctl = '{legal: 1'b1, arith: 1'b1, invert: 1'b0, chain: 1'b0};
      OP_ADC:  ctl = '{legal: 1'b1, arith: 1'b1, invert: 1'b0, chain: 1'b1};
      OP_SUB:  ctl = '{legal: 1'b1, arith: 1'b1, invert: 1'b1, chain: 1'b0};
      OP_SBB:  ctl = '{legal: 1'b1, arith: 1'b1, invert: 1'b1, chain: 1'b1};
      OP_XOR, OP_OR, OP_AND, OP_ANDN, OP_NAND:
               ctl = '{legal: 1'b1, arith: 1'b0, invert: 1'b0, chain: 1'b0};
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/malu_adder.sv
module malu_adder #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              invert,
  input  logic              chain,
  input  logic              flag_in,
  output logic [DATA_W-1:0] sum,
  output logic              cout
);

  localparam int SUM_W = DATA_W + 1;

  logic [DATA_W-1:0] b_eff;
  logic              cin_eff;
  logic [SUM_W-1:0]  full;

  // Subtraction is a + ~b + 1; with borrow the +1 is the flag itself.
  // The carry-out of this sum is the no-borrow indication.
  always_comb begin
    b_eff   = invert ? ~b : b;
    cin_eff = chain ? flag_in : invert;
    full    = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin_eff};
    sum     = full[DATA_W-1:0];
    cout    = full[DATA_W];
  end

endmodule

// File: rtl/malu_logic.sv
module malu_logic
  import malu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [4:0]        op_code,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    unique case (op_code)
      OP_XOR:  y = a ^ b;
      OP_OR:   y = a | b;
      OP_AND:  y = a & b;
      OP_ANDN: y = a & ~b;
      OP_NAND: y = ~(a & b);
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/malu_flag_reg.sv
module malu_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic d,
  output logic q
);

  logic q_nxt;

  always_comb begin
    q_nxt = q;
    if (wr_en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end

  // R8: with no write, the flag holds
  a_r8_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));

endmodule

// File: rtl/macro_alu.sv
module macro_alu
  import malu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [4:0]        op_code,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] result,
  output logic              carry_q,
  output logic              illegal_op
);

  malu_ctl_t         ctl;
  logic [DATA_W-1:0] arith_y;
  logic [DATA_W-1:0] logic_y;
  logic              arith_c;
  logic              flag_wr;

  malu_decode u_dec (
    .op_code (op_code),
    .ctl     (ctl)
  );

  malu_adder #(.DATA_W(DATA_W)) u_add (
    .a       (opnd_a),
    .b       (opnd_b),
    .invert  (ctl.invert),
    .chain   (ctl.chain),
    .flag_in (carry_q),
    .sum     (arith_y),
    .cout    (arith_c)
  );

  malu_logic #(.DATA_W(DATA_W)) u_log (
    .op_code (op_code),
    .a       (opnd_a),
    .b       (opnd_b),
    .y       (logic_y)
  );

  always_comb begin
    flag_wr    = upd_en & ctl.arith;
    illegal_op = ~ctl.legal;
    if (!ctl.legal)     result = '0;
    else if (ctl.arith) result = arith_y;
    else                result = logic_y;
  end

  malu_flag_reg u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (flag_wr),
    .d     (arith_c),
    .q     (carry_q)
  );

  // R1: add sets the flag exactly on unsigned overflow
  a_r1_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_code == OP_ADD) |=> carry_q == ($past(opnd_a) > ~$past(opnd_b)));

  // R3: subtract sets the flag exactly when a >= b
  a_r3_sub_noborrow: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_code == OP_SUB) |=> carry_q == ($past(opnd_a) >= $past(opnd_b)));

  // R4: with the flag set, subtract with borrow behaves as subtract
  a_r4_sbb_set: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_code == OP_SBB && carry_q) |=> carry_q == ($past(opnd_a) >= $past(opnd_b)));

  // R6: bitwise codes keep the flag
  a_r6_logic_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code inside {[5'd8:5'd12]}) |=> $stable(carry_q));

  // R7: unknown codes give zero and keep the flag
  a_r7_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> result == '0);
  a_r7_illegal_keep: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |=> $stable(carry_q));

endmodule

// File: tb/macro_alu_test.sv
module macro_alu_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int M = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         upd_en;
  logic [4:0]   op_code;
  logic [W-1:0] opnd_a, opnd_b;
  logic [W-1:0] result;
  logic         carry_q, illegal_op;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  macro_alu #(.DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
    .carry_q(carry_q), .illegal_op(illegal_op)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (op=%0d a=%0d b=%0d)",
               req, what, act, exp, op_code, opnd_a, opnd_b);
    end
  endtask

  function automatic string tag_of(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      8, 9, 10, 11, 12: return "R5";
      default: return "R7";
    endcase
  endfunction

  // Load the flag with a plain add: 0+0 clears it, M+1 sets it.
  task automatic load_flag(input bit v);
    @(negedge clk);
    upd_en = 1'b1; op_code = 5'd0;
    opnd_a = v ? W'(M) : '0; opnd_b = v ? W'(1) : '0;
    @(negedge clk);
  endtask

  task automatic run_vec(input int op, input int a, input int b, input bit cin, input bit upd);
    int  r_exp, c_new, c_exp, t;
    bit  legal;
    load_flag(cin);
    op_code = 5'(op); opnd_a = W'(a); opnd_b = W'(b); upd_en = upd;
    legal = 1; c_new = cin; r_exp = 0;
    case (op)
      0: begin t = a + b;           r_exp = t & M; c_new = (t > M); end
      1: begin t = a + b + cin;     r_exp = t & M; c_new = (t > M); end
      2: begin t = a - b;           r_exp = t & M; c_new = (t >= 0); end
      3: begin t = a - b - (cin ? 0 : 1); r_exp = t & M; c_new = (t >= 0); end
      8:  r_exp = a ^ b;
      9:  r_exp = a | b;
      10: r_exp = a & b;
      11: r_exp = a & (~b & M);
      12: r_exp = ~(a & b) & M;
      default: begin legal = 0; r_exp = 0; end
    endcase
    #1;
    check(tag_of(op), int'(result), r_exp, "result");
    check("R7", int'(illegal_op), legal ? 0 : 1, "illegal flag");
    c_exp = upd ? c_new : cin;
    @(posedge clk); #1;
    if (!upd)           check("R8", int'(carry_q), c_exp, "flag hold");
    else if (op >= 8 && op <= 12) check("R6", int'(carry_q), c_exp, "flag kept");
    else                check(tag_of(op), int'(carry_q), c_exp, "flag");
  endtask

  initial begin
    rst_n = 1'b0; upd_en = 1'b0; op_code = '0; opnd_a = '0; opnd_b = '0;
    repeat (3) @(negedge clk);
    check("R9", int'(carry_q), 0, "flag in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", int'(carry_q), 0, "flag after reset");

    for (int op = 0; op < 32; op++)
      for (int a = 0; a <= M; a++)
        for (int b = 0; b <= M; b++)
          for (int ci = 0; ci < 2; ci++)
            run_vec(op, a, b, ci[0], ((a + b + op + ci) % 3) != 0);

    // R9: reset in mid-run clears a set flag
    load_flag(1'b1);
    check("R9", int'(carry_q), 1, "flag preloaded");
    rst_n = 1'b0; #1;
    check("R9", int'(carry_q), 0, "flag cleared by reset");
    @(negedge clk); rst_n = 1'b1;

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule